// File: doc/BRIEF.md
# Synchronized Phase-Shifted Carrier PWM

This block drives the switching commands for every submodule of one converter arm. Each submodule has its own triangular carrier. Its gate is high while that submodule's duty reference is above the carrier. The carriers are spread evenly over one switching period, so the arm's combined output steps through more levels and its ripple frequency rises with the submodule count. All carriers are taken from a single phase counter. Every carrier therefore keeps a fixed offset from the first one and never drifts on its own.

Several arm controllers built from this block stay in step through a shared synchronization pulse. The pulse forces the common phase counter back to zero phase, which re-phases the first carrier and all the carriers locked to it. Duty references are sampled only at the valley and the peak of the first carrier. At the default 50 MHz clock and 1 kHz carrier, this gives a 2 kHz update rate. A strobe marks each update. An enable input starts and stops gate driving.

Top module: `pscpwm_arm`

## Requirements
- R1: The carrier of each lane is a symmetric triangle that counts 0, 1, …, HALF_CNT and back down over a period of 2·HALF_CNT clocks. A gate output is registered, so the gate one clock after a phase value reflects the comparison "latched reference > carrier" at that phase.
- R2: Lane k (0-based) uses the phase (p + floor(k·2·HALF_CNT / N_SUB)) mod 2·HALF_CNT, where p is the common phase counter.
- R3: All lanes derive from the one common phase counter, so re-phasing the first carrier re-phases every lane by the same amount.
- R4: A clock edge with sync_in high sets the common phase counter to 0, whatever its value and ahead of its normal count. Counting then resumes from 0.
- R5: References on ref_in are latched only at clock edges where the phase counter is 0 (valley) or HALF_CNT (peak). Changes at other times have no effect on the gates until the next such edge.
- R6: upd_stb is high for exactly the one clock that follows each latching edge, which gives twice per carrier period without sync. In that clock the latched references equal the ref_in values present at the latching edge.
- R7: While en is low, every gate output is low from the next clock on. The phase counter keeps running, so re-enabling does not lose lockstep.
- R8: During reset the phase counter, the latched references, all gates and upd_stb are zero.
- R9: A latched reference of 0 keeps its gate low at all phases. A latched reference greater than HALF_CNT keeps its gate high at all phases while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | Synchronization pulse; re-phases the first carrier to zero |
| en | input | 1 | Gate driving enable |
| ref_in | input | N_SUB·REF_W | Duty references, lane k in bits [k·REF_W +: REF_W], in carrier counts |
| gate_out | output | N_SUB | Gate command per submodule, bit k for lane k |
| upd_stb | output | 1 | One-clock pulse after each reference update |

## Verification
The bench builds the arm with five lanes and HALF_CNT of 7, which gives a 14-clock period. A full period then takes only a few cycles, and sync pulses, reference changes and enable toggles can land on every phase value. With 14 not divisible by 5, the lane offsets are 0, 2, 5, 8 and 11, which exercises the floor rounding of the phase shift. The 4-bit references reach above the peak value of 7, so both the always-off and always-on saturation cases are reachable.

// File: rtl/pscpwm_pkg.sv
package pscpwm_pkg;

  // Offset, in clocks, of lane k inside a carrier period of 2*half clocks.
  function automatic logic [31:0] lane_offset(input logic [31:0] k,
                                              input logic [31:0] n,
                                              input logic [31:0] half);
    return (k * 2 * half) / n;
  endfunction

  // Triangle value at a given phase of a period of 2*half clocks.
  function automatic logic [31:0] carrier_at(input logic [31:0] phase,
                                             input logic [31:0] half);
    return (phase <= half) ? phase : (2 * half - phase);
  endfunction

endpackage

// File: rtl/pscpwm_timer.sv
module pscpwm_timer #(
  parameter int unsigned HALF_CNT = 25000,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  output logic [CNT_W-1:0] ph,
  output logic             upd_evt
);
  localparam int unsigned PERIOD = 2 * HALF_CNT;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] PEAK = CNT_W'(HALF_CNT);

  // One counter serves every lane of the arm.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ph <= '0;
    else if (sync_in)      ph <= '0;
    else if (ph == LAST)   ph <= '0;
    else                   ph <= ph + 1'b1;
  end

  // Valley or peak of the first carrier.
  assign upd_evt = (ph == '0) || (ph == PEAK);

  p_sync_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (ph == '0));

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == LAST && !sync_in) |=> (ph == '0));

  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= LAST);

endmodule

// File: rtl/pscpwm_ref_bank.sv
module pscpwm_ref_bank #(
  parameter int unsigned N_SUB = 5,
  parameter int unsigned REF_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_evt,
  input  logic [N_SUB*REF_W-1:0] ref_in,
  output logic [N_SUB*REF_W-1:0] ref_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ref_q <= '0;
    else if (upd_evt) ref_q <= ref_in;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(ref_q));

endmodule

// File: rtl/pscpwm_lane.sv
module pscpwm_lane #(
  parameter int unsigned LANE     = 0,
  parameter int unsigned N_SUB    = 5,
  parameter int unsigned HALF_CNT = 25000,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned REF_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] ph,
  input  logic [REF_W-1:0] ref_lane,
  output logic             gate
);
  import pscpwm_pkg::*;

  localparam logic [31:0] PERIOD = 32'(2 * HALF_CNT);
  localparam logic [31:0] OFF    = lane_offset(LANE, N_SUB, HALF_CNT);

  logic [31:0] ph_sum;
  logic [31:0] lane_ph;
  logic [31:0] carrier;

  assign ph_sum  = 32'(ph) + OFF;
  assign lane_ph = (ph_sum >= PERIOD) ? (ph_sum - PERIOD) : ph_sum;
  assign carrier = carrier_at(lane_ph, HALF_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= en && (32'(ref_lane) > carrier);
  end

  p_zero_ref_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_lane == '0) |=> !gate);

  p_lane_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_ph < PERIOD);

endmodule

// File: rtl/pscpwm_arm.sv
module pscpwm_arm #(
  parameter int unsigned N_SUB    = 5,
  parameter int unsigned HALF_CNT = 25000,   // 50 MHz clock, 1 kHz carrier
  parameter int unsigned CNT_W    = $clog2(2 * HALF_CNT),
  parameter int unsigned REF_W    = CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_in,
  input  logic                   en,
  input  logic [N_SUB*REF_W-1:0] ref_in,
  output logic [N_SUB-1:0]       gate_out,
  output logic                   upd_stb
);
  logic [CNT_W-1:0]       ph;
  logic                   upd_evt;
  logic [N_SUB*REF_W-1:0] ref_q;

  pscpwm_timer #(.HALF_CNT(HALF_CNT), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .ph(ph), .upd_evt(upd_evt)
  );

  pscpwm_ref_bank #(.N_SUB(N_SUB), .REF_W(REF_W)) u_refs (
    .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .ref_in(ref_in), .ref_q(ref_q)
  );

  for (genvar k = 0; k < N_SUB; k++) begin : g_lane
    pscpwm_lane #(
      .LANE(k), .N_SUB(N_SUB), .HALF_CNT(HALF_CNT), .CNT_W(CNT_W), .REF_W(REF_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en), .ph(ph),
      .ref_lane(ref_q[k*REF_W +: REF_W]), .gate(gate_out[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_stb <= 1'b0;
    else        upd_stb <= upd_evt;
  end

  p_disable_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_out == '0));

  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> (ref_q == $past(ref_in)));

endmodule

// File: tb/pscpwm_arm_test.sv
module pscpwm_arm_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int H  = 7;
  localparam int P  = 2 * H;
  localparam int W  = $clog2(P);
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic en = 1'b0;
  logic [N*W-1:0] ref_in = '0;
  logic [N-1:0] gate_out;
  logic upd_stb;

  int n_run = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Behavioural model state
  int m_ph = 0;
  int m_ref [N];
  logic [N-1:0] e_gate = '0;
  logic e_stb = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pscpwm_arm #(.N_SUB(N), .HALF_CNT(H)) uut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .en(en),
    .ref_in(ref_in), .gate_out(gate_out), .upd_stb(upd_stb)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0;
      foreach (m_ref[i]) m_ref[i] = 0;
      e_gate = '0;
      e_stb = 1'b0;
    end else begin
      for (int k = 0; k < N; k++) begin
        int lp, c;
        lp = (m_ph + (k * P) / N) % P;
        c  = (lp <= H) ? lp : P - lp;
        e_gate[k] = en && (m_ref[k] > c);
      end
      e_stb = (m_ph == 0) || (m_ph == H);
      if (e_stb)
        for (int k = 0; k < N; k++) m_ref[k] = int'(ref_in[k*W +: W]);
      m_ph = sync_in ? 0 : (m_ph + 1) % P;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check(gate_out == e_gate, cur_req, "gate_out", int'(gate_out), int'(e_gate));
      check(upd_stb == e_stb, "R6", "upd_stb", int'(upd_stb), int'(e_stb));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_refs(input int a, input int b, input int c, input int d, input int e);
    ref_in = {W'(e), W'(d), W'(c), W'(b), W'(a)};
  endtask

  initial begin
    tick(3);
    // R8: reset state
    check(gate_out == '0, "R8", "gate in reset", int'(gate_out), 0);
    check(upd_stb == 1'b0, "R8", "strobe in reset", int'(upd_stb), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R1, R2, R9: mixed references incl. 0 and above the peak
    cur_req = "R1";
    en = 1'b1;
    set_refs(0, 3, 7, 8, 5);
    tick(3 * P);
    cur_req = "R2";
    set_refs(2, 6, 1, 4, 15);
    tick(2 * P + 3);

    // R5: references change away from valley and peak
    cur_req = "R5";
    for (int i = 0; i < 4 * P; i++) begin
      if ((i % 3) == 1) ref_in = N*W'($urandom);
      tick(1);
    end

    // R6: exactly two strobes per period
    begin
      int cnt = 0;
      for (int i = 0; i < P; i++) begin
        tick(1);
        if (upd_stb) cnt++;
      end
      check(cnt == 2, "R6", "strobes per period", cnt, 2);
    end

    // R4 / R3: sync pulses at assorted phases
    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin
      tick(3 + i * 2);
      sync_in = 1'b1;
      tick(1);
      sync_in = 1'b0;
      tick(1);
      check(upd_stb == 1'b1, "R4", "strobe after sync", int'(upd_stb), 1);
    end
    cur_req = "R3";
    set_refs(4, 4, 4, 4, 4);
    sync_in = 1'b1;
    tick(1);
    sync_in = 1'b0;
    tick(3 * P);

    // R9: all zero, then all above peak
    cur_req = "R9";
    set_refs(0, 0, 0, 0, 0);
    tick(P + 2);
    begin
      bit any = 1'b0;
      for (int i = 0; i < P; i++) begin
        tick(1);
        if (gate_out != '0) any = 1'b1;
      end
      check(!any, "R9", "zero ref gate", int'(any), 0);
    end
    set_refs(9, 15, 8, 12, 10);
    tick(P + 2);
    begin
      bit all_hi = 1'b1;
      for (int i = 0; i < P; i++) begin
        tick(1);
        if (gate_out != '1) all_hi = 1'b0;
      end
      check(all_hi, "R9", "saturated ref gate", int'(all_hi), 1);
    end

    // R7: disable keeps gates low, counter keeps running
    cur_req = "R7";
    set_refs(3, 5, 7, 9, 15);
    tick(P);
    en = 1'b0;
    tick(1);
    check(gate_out == '0, "R7", "gate when disabled", int'(gate_out), 0);
    tick(2 * P);
    en = 1'b1;
    tick(2 * P);

    chk_on = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule